// File: doc/BRIEF.md
# Offset Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It counts input-cycle enables, each one standing for one cycle of the divided signal. After N of them it sends one pulse toward the phase detector. The divide ratio N comes from a 14-bit parallel ratio word and a transmit/receive select. When the select is low, a fixed offset of 856 is added to the word. When the select is high, the word is used as it is. Every piece of logic runs in one clock domain.

The ratio and the select may change at any time. The counter takes them in only when a divide cycle ends, or while reset is applied, so every divide cycle has the full length that was in force when it began. If the sum falls outside the legal range of 3 to 16383, the divisor is clamped to the nearest limit and a range-error flag is raised. The flag stays set for as long as the clamped divisor is in use. Boards normally tie unused ratio bits and the select high, which gives the largest ratio without an offset.

Top module: `offset_fbdiv`

## Requirements
- R1: Reset is synchronous and active-low (`rst_n`). While `rst_n` is low, `fv_pulse` is 0. The divisor is loaded from the present `ratio_word` and `tr_sel`, and `range_err` shows the range state of those values.
- R2: With `tr_sel` high, `fv_pulse` fires once for every N accepted enables, where N is `ratio_word` read as an unsigned binary number with bit 0 as the LSB.
- R3: With `tr_sel` low, N equals `ratio_word` + 856.
- R4: `fv_pulse` is high for exactly one clock. It rises in the cycle after the clock edge that accepts the Nth enable. A cycle with `in_en` low does not advance the count.
- R5: If the sum exceeds 16383, N is 16383 and `range_err` is 1.
- R6: If the sum is below 3, N is 3 and `range_err` is 1. A sum from 3 to 16383 gives `range_err` = 0.
- R7: A change of `ratio_word` or `tr_sel` during a divide cycle does not alter that cycle's length. The new values are sampled on the clock edge that accepts the terminal enable.
- R8: `range_err` changes only on the edge where a divisor is loaded, that is, at reset or at a terminal enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_en | input | 1 | One input cycle to be counted |
| ratio_word | input | 14 | Programmed divide ratio, bit 0 is the LSB |
| tr_sel | input | 1 | Low: add offset 856; high: no offset |
| fv_pulse | output | 1 | One-clock feedback pulse per divide cycle |
| range_err | output | 1 | Divisor in use was clamped |

## Verification
Assertions check four things on every cycle: the pulse is one clock wide, it appears only after an accepted enable, the count and flag hold in idle cycles, and the flag changes only at a divisor load. A clamped divisor must also sit on one of the two limits. Only the bench's scenarios can show the actual divide lengths: the offset and no-offset ratios, both clamp limits, the hold of the old length when the inputs change mid-cycle, sparse enables, and a reload by reset. The bench shows these by counting enables between pulses against its own model.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    // Default counter width, offset and smallest legal divisor
    localparam int FBD_CNT_W   = 14;
    localparam int FBD_OFFSET  = 856;
    localparam int FBD_MIN_DIV = 3;

    // Result of range evaluation on the requested divisor
    typedef enum logic [1:0] {
        RNG_OK   = 2'd0,
        RNG_LOW  = 2'd1,
        RNG_HIGH = 2'd2
    } rng_e;

endpackage

// File: rtl/fbdiv_ratio_calc.sv
module fbdiv_ratio_calc
    import fbdiv_pkg::*;
#(
    parameter int CNT_W   = FBD_CNT_W,
    parameter int OFFSET  = FBD_OFFSET,
    parameter int MIN_DIV = FBD_MIN_DIV
) (
    input  logic [CNT_W-1:0] ratio_i,
    input  logic             tr_sel_i,
    output logic [CNT_W-1:0] div_m1_o,
    output rng_e             rng_o
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] MAX_S = SUM_W'((1 << CNT_W) - 1);
    localparam logic [SUM_W-1:0] MIN_S = SUM_W'(MIN_DIV);

    logic [SUM_W-1:0] off_add;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] div;

    // The parameter picks whether an offset adder exists at all
    generate
        if (OFFSET == 0) begin : g_no_off
            assign off_add = '0;
        end else begin : g_off
            assign off_add = tr_sel_i ? '0 : SUM_W'(OFFSET);
        end
    endgenerate

    assign sum = {1'b0, ratio_i} + off_add;

    always_comb begin
        if (sum > MAX_S) begin
            div   = MAX_S[CNT_W-1:0];
            rng_o = RNG_HIGH;
        end else if (sum < MIN_S) begin
            div   = MIN_S[CNT_W-1:0];
            rng_o = RNG_LOW;
        end else begin
            div   = sum[CNT_W-1:0];
            rng_o = RNG_OK;
        end
        div_m1_o = div - 1'b1;
    end

    // R5 R6
    always_comb begin
        if (rng_o != RNG_OK) begin
            clamp_edge_chk: assert (div == MAX_S[CNT_W-1:0] || div == MIN_S[CNT_W-1:0]);
        end
    end

endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
    import fbdiv_pkg::*;
#(
    parameter int CNT_W = FBD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [CNT_W-1:0] load_m1_i,
    input  logic             load_err_i,
    output logic             fv_o,
    output logic             err_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
        logic             fv;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       term;

    assign term = in_en && (st_q.cnt == '0);

    always_comb begin
        st_d    = st_q;
        st_d.fv = 1'b0;
        if (!rst_n) begin
            st_d.cnt = load_m1_i;
            st_d.err = load_err_i;
        end else if (in_en) begin
            if (term) begin
                st_d.fv  = 1'b1;
                st_d.cnt = load_m1_i;
                st_d.err = load_err_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fv_o  = st_q.fv;
    assign err_o = st_q.err;

    // R4
    fv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fv |=> !st_q.fv);

    // R4
    fv_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fv |-> $past(in_en));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> $stable(st_q.cnt));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(st_q.err));

endmodule

// File: rtl/offset_fbdiv.sv
module offset_fbdiv
    import fbdiv_pkg::*;
#(
    parameter int CNT_W   = FBD_CNT_W,
    parameter int OFFSET  = FBD_OFFSET,
    parameter int MIN_DIV = FBD_MIN_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [CNT_W-1:0] ratio_word,
    input  logic             tr_sel,
    output logic             fv_pulse,
    output logic             range_err
);

    logic [CNT_W-1:0] div_m1;
    rng_e             rng;

    fbdiv_ratio_calc #(
        .CNT_W  (CNT_W),
        .OFFSET (OFFSET),
        .MIN_DIV(MIN_DIV)
    ) u_calc (
        .ratio_i (ratio_word),
        .tr_sel_i(tr_sel),
        .div_m1_o(div_m1),
        .rng_o   (rng)
    );

    fbdiv_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_en     (in_en),
        .load_m1_i (div_m1),
        .load_err_i(rng != RNG_OK),
        .fv_o      (fv_pulse),
        .err_o     (range_err)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !fv_pulse);

endmodule

// File: tb/offset_fbdiv_tb.sv
module offset_fbdiv_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_en = 1'b0;
    logic [13:0] ratio_word = 14'd5;
    logic        tr_sel = 1'b1;
    logic        fv_pulse;
    logic        range_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int m_left = 0;
    int m_err = 0;
    int m_fv = 0;
    int en_since = 0;
    int last_period = -1;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    offset_fbdiv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_en     (in_en),
        .ratio_word(ratio_word),
        .tr_sel    (tr_sel),
        .fv_pulse  (fv_pulse),
        .range_err (range_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int want_div(input int r, input bit tr, output int e);
        int s = r + (tr ? 0 : 856);
        e = 0;
        if (s > 16383) begin e = 1; return 16383; end
        if (s < 3)     begin e = 1; return 3; end
        return s;
    endfunction

    task automatic cyc(input bit en);
        int e;
        int d;
        @(negedge clk);
        in_en = en;
        d = want_div(int'(ratio_word), tr_sel, e);
        if (!rst_n) begin
            m_left = d - 1; m_err = e; m_fv = 0; en_since = 0;
        end else if (en) begin
            en_since++;
            if (m_left == 0) begin
                m_fv = 1; m_left = d - 1; m_err = e;
            end else begin
                m_left--; m_fv = 0;
            end
        end else begin
            m_fv = 0;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        cycles++;
        chk("R4 fv_pulse", int'(fv_pulse), m_fv);
        chk("R8 range_err", int'(range_err), m_err);
        if (fv_pulse) begin
            last_period = en_since;
            en_since = 0;
        end
    endtask

    task automatic run_pulses(input int k, input int gap);
        int seen = 0;
        int i = 0;
        while (seen < k && i < 40000) begin
            cyc((i % gap) == 0);
            if (fv_pulse) seen++;
            i++;
        end
        if (seen < k) chk("watchdog pulses", seen, k);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset loads ratio 5, no offset
        rst_n = 1'b0; ratio_word = 14'd5; tr_sel = 1'b1;
        cyc(1'b1); cyc(1'b0);
        chk("R1 fv low in reset", int'(fv_pulse), 0);
        chk("R1 flag in reset", int'(range_err), 0);
        rst_n = 1'b1;

        // R2: plain ratio
        run_pulses(3, 1);
        chk("R2 period 5", last_period, 5);

        // R3: offset added when select low
        ratio_word = 14'd10; tr_sel = 1'b0;
        run_pulses(2, 1);
        chk("R3 period 866", last_period, 866);

        // R7: mid-cycle change keeps the running length
        for (int i = 0; i < 100; i++) cyc(1'b1);
        ratio_word = 14'd4; tr_sel = 1'b1;
        run_pulses(1, 1);
        chk("R7 old length kept", last_period, 866);
        run_pulses(1, 1);
        chk("R2 new length 4", last_period, 4);

        // R4: sparse enables, ratio 7
        ratio_word = 14'd7;
        run_pulses(2, 3);
        chk("R4 sparse period 7", last_period, 7);

        // R6: below minimum clamps to 3
        ratio_word = 14'd2;
        run_pulses(2, 1);
        chk("R6 low clamp period", last_period, 3);
        chk("R6 low clamp flag", int'(range_err), 1);
        ratio_word = 14'd0;
        run_pulses(2, 1);
        chk("R6 zero clamp period", last_period, 3);

        // R6: boundary 3 is legal
        ratio_word = 14'd3;
        run_pulses(2, 1);
        chk("R6 min legal period", last_period, 3);
        chk("R6 min legal flag", int'(range_err), 0);

        // R5: sum above maximum clamps to 16383
        ratio_word = 14'd16000; tr_sel = 1'b0;
        run_pulses(2, 1);
        chk("R5 high clamp period", last_period, 16383);
        chk("R5 high clamp flag", int'(range_err), 1);

        // R2: all ones, no offset, is legal
        ratio_word = 14'h3FFF; tr_sel = 1'b1;
        run_pulses(2, 1);
        chk("R2 max legal period", last_period, 16383);
        chk("R2 max legal flag", int'(range_err), 0);

        // R1: reset mid-cycle reloads from present inputs
        ratio_word = 14'd6;
        for (int i = 0; i < 50; i++) cyc(1'b1);
        rst_n = 1'b0;
        cyc(1'b1); cyc(1'b1);
        chk("R1 fv low in reset", int'(fv_pulse), 0);
        rst_n = 1'b1;
        run_pulses(1, 1);
        chk("R1 reload period", last_period, 6);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule